// File: doc/BRIEF.md
# I2C Master Transaction Controller

This block is a single-master I2C controller that carries out one complete bus transaction for each command it accepts. On a start command it produces the start condition and sends the target address. The address is either a 7-bit address followed by the read/write bit, or a two-byte 10-bit header. It then writes or reads the requested number of data bytes and finishes with a stop condition. After every byte it either checks the target's acknowledge (when the master transmitted) or gives one (when the master received).

The host presents the address, the addressing mode, the direction, the byte count and the speed mode, then pulses `cmdStart`. During a write it supplies each byte on `wrData` and is told by `wrTake` that the byte was taken. During a read it receives each byte on `rdData` with a one-cycle `rdValid`. The bus pins are open-drain style: `sclOut` and `sdaOut` at 1 mean released and at 0 mean pulled low. `sdaIn` is the resolved SDA level. Multi-master arbitration, clock stretching and target mode are not part of this block.

SCL high and low durations are counts of the system clock, and each speed mode has its own pair of counts. The controller stops the transfer with an error when a byte is not acknowledged. It also stops with an error when the target keeps SDA low for too long after its acknowledge.

Top module: `i2c_txn_master`

## Requirements
- R1: After reset and between transactions both bus lines are released (`sclOut`=1, `sdaOut`=1) and `busy` and `done` are 0.
- R2: A `cmdStart` seen while idle makes `busy` 1 from the next cycle. For the next high-count cycles SCL stays released with SDA low (start condition). SDA changes while SCL is released only at start and stop.
- R3: Each bit keeps SCL low for the mode's low count and then releases it for the mode's high count. SDA is set while SCL is low, most significant bit first, and `sdaIn` is sampled in the last released cycle. `speedMode` 0 selects standard counts, 1 selects fast counts, and 2 or 3 select high-speed counts.
- R4: In 7-bit mode (`cmdTenBit`=0) the first byte is `{cmdAddr[6:0], rw}`, where rw is 1 for read and 0 for write. Address 0x51 with write therefore sends 0xA2.
- R5: In 10-bit mode the first byte is `{11110, cmdAddr[9:8], rw}` and the second byte is `cmdAddr[7:0]`, each followed by its own acknowledge slot.
- R6: In the ninth bit of a byte sent by the master, SDA is released and a sampled low means acknowledge. After an acknowledge the controller holds SCL low with SDA released and continues in the first cycle in which `sdaIn` is high.
- R7: On a write, each data byte is taken from `wrData` as that byte begins, and `wrTake` is high for exactly the first cycle of that byte.
- R8: On a read, SDA is released for eight bits and the bits are assembled MSB first. `rdValid` pulses with the byte on `rdData` in the first cycle of the acknowledge slot. The master pulls SDA low in that slot for every byte except the last, where it leaves SDA released.
- R9: A high level sampled in the acknowledge slot of any byte the master sent ends the transfer with a stop condition and `error`=1.
- R10: If `sdaIn` is still low after the hold-timeout count of cycles in the post-acknowledge wait, the transfer ends with a stop condition and `error`=1.
- R11: The stop sequence is three steps: SCL low with SDA low for the low count; then SCL released with SDA low for the high count; then both released for the high count. Then `done` is high for one cycle, `busy` falls, and `error` holds its value until the next accepted start.
- R12: With `cmdCount`=0 only the address is sent before the stop. `cmdStart` and changes of the command inputs while `busy` have no effect on the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Starts a transaction when idle |
| cmdAddr | input | 10 | Target address (low 7 bits used in 7-bit mode) |
| cmdTenBit | input | 1 | 1 selects 10-bit addressing |
| cmdRead | input | 1 | 1 for read, 0 for write |
| cmdCount | input | CountW | Number of data bytes |
| speedMode | input | 2 | 0 standard, 1 fast, 2/3 high-speed |
| wrData | input | 8 | Next byte to write |
| wrTake | output | 1 | Pulse: wrData was taken |
| rdData | output | 8 | Last byte read |
| rdValid | output | 1 | Pulse: rdData holds a new byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at transaction end |
| error | output | 1 | Last transaction ended on NACK or timeout |
| sclOut | output | 1 | SCL: 1 released, 0 pulled low |
| sdaOut | output | 1 | SDA: 1 released, 0 pulled low |
| sdaIn | input | 1 | Resolved SDA level |

## Verification
The bench exercises several corner cases and names the failure each would reveal. A missing address acknowledge and a missing data acknowledge partway through a write are both tested; a controller that kept going after either would clock out extra bytes instead of stopping, and the waveform comparison would diverge. A target that holds SDA low after its acknowledge must end in a stop after exactly the timeout count; a wrong counter bound would shift the stop by some cycles. The bench also checks the 10-bit header bit layout, the final NACK of a read (a design that acknowledged the last byte would hold SDA low there), the zero-byte address probe, and a start command fired in the middle of a transfer, which must leave the waveform untouched.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BLOW, S_BHIGH, S_WREL, S_SLOW, S_SHIGH, S_SFREE
  } busState_t;

  typedef enum logic [1:0] {K_ADDR1, K_ADDR2, K_DATA} byteKind_t;

  typedef struct packed {
    logic latchCmd;
    logic loadAddr2;
    logic loadData;
    logic shiftTx;
    logic sampleRx;
    logic publishRx;
  } ctlStrobe_t;
endpackage

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          stb,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic                cmdTenBit,
  input  logic                cmdRead,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic                sdaIn,
  output logic                txBit,
  output logic [BYTE_W-1:0]   rdData,
  output logic                rdValid,
  output logic                wrTake
);
  logic [BYTE_W-1:0] addrLo;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-2:0] rxShift;
  logic [BYTE_W-1:0] firstByte;

  always_comb begin
    if (cmdTenBit) firstByte = {TEN_BIT_TAG, cmdAddr[9:8], cmdRead};
    else           firstByte = {cmdAddr[6:0], cmdRead};
  end

  assign txBit = txShift[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLo  <= '0;
      txShift <= '0;
      rxShift <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
      wrTake  <= 1'b0;
    end else begin
      rdValid <= stb.publishRx;
      wrTake  <= stb.loadData;
      if (stb.latchCmd) begin
        addrLo  <= cmdAddr[7:0];
        txShift <= firstByte;
      end else if (stb.loadAddr2) begin
        txShift <= addrLo;
      end else if (stb.loadData) begin
        txShift <= wrData;
      end else if (stb.shiftTx) begin
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end
      if (stb.sampleRx) rxShift <= {rxShift[BYTE_W-3:0], sdaIn};
      if (stb.publishRx) rdData <= {rxShift, sdaIn};
    end
  end

  // R7 R8: a read byte and a write byte never complete in the same cycle
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && wrTake));
endmodule

// File: rtl/i2cm_control.sv
module i2cm_control
  import i2cm_pkg::*;
#(
  parameter int StdLow      = 500,
  parameter int StdHigh     = 400,
  parameter int FastLow     = 130,
  parameter int FastHigh    = 110,
  parameter int HsLow       = 20,
  parameter int HsHigh      = 12,
  parameter int HoldTimeout = 1000,
  parameter int CountW      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdTenBit,
  input  logic              cmdRead,
  input  logic [CountW-1:0] cmdCount,
  input  logic [1:0]        speedMode,
  input  logic              sdaIn,
  input  logic              txBit,
  output ctlStrobe_t        stb,
  output logic              sclOut,
  output logic              sdaOut,
  output logic              busy,
  output logic              done,
  output logic              error
);
  localparam int MaxA   = (StdLow > StdHigh) ? StdLow : StdHigh;
  localparam int MaxB   = (FastLow > FastHigh) ? FastLow : FastHigh;
  localparam int MaxC   = (HsLow > HsHigh) ? HsLow : HsHigh;
  localparam int MaxAB  = (MaxA > MaxB) ? MaxA : MaxB;
  localparam int MaxABC = (MaxAB > MaxC) ? MaxAB : MaxC;
  localparam int MaxLen = (MaxABC > HoldTimeout) ? MaxABC : HoldTimeout;
  localparam int TimerW = $clog2(MaxLen + 1);

  busState_t         state, nState;
  byteKind_t         kind, nKind;
  logic [TimerW-1:0] timer, lenLow, lenHigh, curLen;
  logic [3:0]        bitIdx;
  logic [CountW-1:0] remain, remAfter;
  logic [1:0]        modeR;
  logic              tenBitR, readR, errPend;
  logic              segEnd, txByte, lastRx, bitSda;
  logic              bitClr, bitInc, remDec, abort, finish;

  always_comb begin
    case (modeR)
      2'd0:    begin lenLow = TimerW'(StdLow);  lenHigh = TimerW'(StdHigh);  end
      2'd1:    begin lenLow = TimerW'(FastLow); lenHigh = TimerW'(FastHigh); end
      default: begin lenLow = TimerW'(HsLow);   lenHigh = TimerW'(HsHigh);   end
    endcase
  end

  always_comb begin
    case (state)
      S_START, S_BHIGH, S_SHIGH, S_SFREE: curLen = lenHigh;
      default:                            curLen = lenLow;
    endcase
  end

  assign segEnd   = (timer == curLen - 1'b1);
  assign txByte   = (kind != K_DATA) || !readR;
  assign lastRx   = (remain == CountW'(1));
  assign remAfter = (kind == K_DATA) ? remain - 1'b1 : remain;
  assign bitSda   = (bitIdx == 4'd8) ? (txByte ? 1'b1 : lastRx)
                                     : (txByte ? txBit : 1'b1);
  assign busy     = (state != S_IDLE);

  always_comb begin
    case (state)
      S_START: begin sclOut = 1'b1; sdaOut = 1'b0;   end
      S_BLOW:  begin sclOut = 1'b0; sdaOut = bitSda; end
      S_BHIGH: begin sclOut = 1'b1; sdaOut = bitSda; end
      S_WREL:  begin sclOut = 1'b0; sdaOut = 1'b1;   end
      S_SLOW:  begin sclOut = 1'b0; sdaOut = 1'b0;   end
      S_SHIGH: begin sclOut = 1'b1; sdaOut = 1'b0;   end
      default: begin sclOut = 1'b1; sdaOut = 1'b1;   end
    endcase
  end

  always_comb begin
    stb = '0; nState = state; nKind = kind;
    bitClr = 1'b0; bitInc = 1'b0; remDec = 1'b0; abort = 1'b0; finish = 1'b0;
    case (state)
      S_IDLE: if (cmdStart) begin stb.latchCmd = 1'b1; nState = S_START; end
      S_START: if (segEnd) begin bitClr = 1'b1; nState = S_BLOW; end
      S_BLOW: if (segEnd) nState = S_BHIGH;
      S_BHIGH: if (segEnd) begin
        if (bitIdx != 4'd8) begin
          if (txByte) stb.shiftTx = 1'b1;
          else begin
            stb.sampleRx  = 1'b1;
            stb.publishRx = (bitIdx == 4'd7);
          end
          bitInc = 1'b1;
          nState = S_BLOW;
        end else if (!txByte) begin
          remDec = 1'b1; bitClr = 1'b1;
          nState = lastRx ? S_SLOW : S_BLOW;
        end else if (sdaIn) begin
          abort = 1'b1; nState = S_SLOW;
        end else nState = S_WREL;
      end
      S_WREL: if (sdaIn) begin
        bitClr = 1'b1; nState = S_BLOW;
        if (kind == K_ADDR1 && tenBitR) begin
          nKind = K_ADDR2; stb.loadAddr2 = 1'b1;
        end else begin
          nKind  = K_DATA;
          remDec = (kind == K_DATA);
          if (remAfter == '0) nState = S_SLOW;
          else if (!readR) stb.loadData = 1'b1;
        end
      end else if (timer == TimerW'(HoldTimeout - 1)) begin
        abort = 1'b1; nState = S_SLOW;
      end
      S_SLOW:  if (segEnd) nState = S_SHIGH;
      S_SHIGH: if (segEnd) nState = S_SFREE;
      S_SFREE: if (segEnd) begin finish = 1'b1; nState = S_IDLE; end
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; kind <= K_ADDR1; timer <= '0; bitIdx <= '0;
      remain <= '0; modeR <= '0; tenBitR <= 1'b0; readR <= 1'b0;
      errPend <= 1'b0; error <= 1'b0; done <= 1'b0;
    end else begin
      state <= nState;
      done  <= finish;
      if (state == S_IDLE || nState != state) timer <= '0;
      else timer <= timer + 1'b1;
      if (bitClr) bitIdx <= '0;
      else if (bitInc) bitIdx <= bitIdx + 1'b1;
      if (stb.latchCmd) begin
        tenBitR <= cmdTenBit; readR <= cmdRead; remain <= cmdCount;
        modeR <= speedMode; kind <= K_ADDR1; errPend <= 1'b0; error <= 1'b0;
      end else begin
        kind <= nKind;
        if (remDec) remain <= remain - 1'b1;
        if (abort) errPend <= 1'b1;
        if (finish) error <= errPend;
      end
    end
  end

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclOut && sdaOut));
  // R2
  sda_edge_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sclOut) && sclOut && (sdaOut != $past(sdaOut))) |->
      ((state == S_START && !sdaOut) || (state == S_SFREE && sdaOut)));
  // R12
  start_only_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdStart));
  // R10
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WREL) |-> (timer < TimerW'(HoldTimeout)));
  // R9
  error_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> done);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/i2c_txn_master.sv
module i2c_txn_master
  import i2cm_pkg::*;
#(
  parameter int StdLow      = 500,
  parameter int StdHigh     = 400,
  parameter int FastLow     = 130,
  parameter int FastHigh    = 110,
  parameter int HsLow       = 20,
  parameter int HsHigh      = 12,
  parameter int HoldTimeout = 1000,
  parameter int CountW      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [9:0]        cmdAddr,
  input  logic              cmdTenBit,
  input  logic              cmdRead,
  input  logic [CountW-1:0] cmdCount,
  input  logic [1:0]        speedMode,
  input  logic [7:0]        wrData,
  output logic              wrTake,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              sclOut,
  output logic              sdaOut,
  input  logic              sdaIn
);
  ctlStrobe_t stb;
  logic       txBit;

  i2cm_control #(
    .StdLow(StdLow), .StdHigh(StdHigh), .FastLow(FastLow), .FastHigh(FastHigh),
    .HsLow(HsLow), .HsHigh(HsHigh), .HoldTimeout(HoldTimeout), .CountW(CountW)
  ) uCtl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdTenBit(cmdTenBit),
    .cmdRead(cmdRead), .cmdCount(cmdCount), .speedMode(speedMode),
    .sdaIn(sdaIn), .txBit(txBit), .stb(stb), .sclOut(sclOut),
    .sdaOut(sdaOut), .busy(busy), .done(done), .error(error)
  );

  i2cm_datapath uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdAddr(cmdAddr),
    .cmdTenBit(cmdTenBit), .cmdRead(cmdRead), .wrData(wrData),
    .sdaIn(sdaIn), .txBit(txBit), .rdData(rdData), .rdValid(rdValid),
    .wrTake(wrTake)
  );
endmodule

// File: tb/sim_i2c_txn_master.sv
module sim_i2c_txn_master;
  localparam int SL = 6, SH = 5, FL = 4, FH = 3, HL = 2, HH = 2, TO = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 1'b0;
  logic [9:0] cmdAddr = '0;
  logic cmdTenBit = 1'b0, cmdRead = 1'b0;
  logic [7:0] cmdCount = '0;
  logic [1:0] speedMode = '0;
  logic [7:0] wrData = '0;
  logic wrTake, rdValid, busy, done, error, sclOut, sdaOut, sdaIn;
  logic [7:0] rdData;
  logic tgt = 1'b1;

  assign sdaIn = tgt & sdaOut;
  always #4 clk = ~clk;

  i2c_txn_master #(.StdLow(SL), .StdHigh(SH), .FastLow(FL), .FastHigh(FH),
    .HsLow(HL), .HsHigh(HH), .HoldTimeout(TO), .CountW(8)) u0 (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdAddr(cmdAddr),
    .cmdTenBit(cmdTenBit), .cmdRead(cmdRead), .cmdCount(cmdCount),
    .speedMode(speedMode), .wrData(wrData), .wrTake(wrTake), .rdData(rdData),
    .rdValid(rdValid), .busy(busy), .done(done), .error(error),
    .sclOut(sclOut), .sdaOut(sdaOut), .sdaIn(sdaIn));

  int checks = 0, fails = 0;
  int expQ[$];
  logic [7:0] rxQ[$];
  logic [7:0] txBytes[0:7];
  logic [7:0] rxBytes[0:7];
  int nackMask, holdIdx, txIdx, lenL, lenH;
  bit modelErr, stopped;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit s, input bit m, input bit t, input int n,
                      input bit take, input bit rdv, input bit ack);
    for (int i = 0; i < n; i++)
      expQ.push_back(int'(s) | (int'(m) << 1) | (int'(t) << 2) |
        (int'(take && i == 0) << 3) | (int'(rdv && i == 0) << 4) | (int'(ack) << 5));
  endtask

  task automatic sendTx(input logic [7:0] b, input bit take);
    for (int i = 7; i >= 0; i--) begin
      push(0, b[i], 1, lenL, take && i == 7, 0, 0);
      push(1, b[i], 1, lenH, 0, 0, 0);
    end
    push(0, 1, nackMask[txIdx], lenL, 0, 0, 1);
    push(1, 1, nackMask[txIdx], lenH, 0, 0, 1);
    if (nackMask[txIdx]) begin modelErr = 1; stopped = 1; end
    else if (txIdx == holdIdx) begin push(0, 1, 0, TO, 0, 0, 1); modelErr = 1; stopped = 1; end
    else push(0, 1, 1, 1, 0, 0, 1);
    txIdx++;
  endtask

  task automatic recvByte(input logic [7:0] b, input bit last);
    for (int i = 7; i >= 0; i--) begin
      push(0, 1, b[i], lenL, 0, 0, 0);
      push(1, 1, b[i], lenH, 0, 0, 0);
    end
    push(0, last, 1, lenL, 0, 1, 1);
    push(1, last, 1, lenH, 0, 0, 1);
    rxQ.push_back(b);
  endtask

  task automatic runTxn(input string tag, input logic [9:0] a, input bit ten,
                        input bit rd, input int cnt, input int mode, input bit poke);
    int e, cyc, wi;
    lenL = (mode == 0) ? SL : (mode == 1) ? FL : HL;
    lenH = (mode == 0) ? SH : (mode == 1) ? FH : HH;
    expQ.delete(); rxQ.delete();
    modelErr = 0; stopped = 0; txIdx = 0;
    push(1, 0, 1, lenH, 0, 0, 0);
    if (ten) begin
      sendTx({5'b11110, a[9:8], rd}, 0);
      if (!stopped) sendTx(a[7:0], 0);
    end else sendTx({a[6:0], rd}, 0);
    if (!stopped) begin
      for (int k = 0; k < cnt && !stopped; k++) begin
        if (rd) recvByte(rxBytes[k], k == cnt - 1);
        else sendTx(txBytes[k], 1);
      end
    end
    push(0, 0, 1, lenL, 0, 0, 0);
    push(1, 0, 1, lenH, 0, 0, 0);
    push(1, 1, 1, lenH, 0, 0, 0);

    wi = 0;
    wrData = txBytes[0];
    @(negedge clk);
    cmdAddr = a; cmdTenBit = ten; cmdRead = rd; cmdCount = 8'(cnt);
    speedMode = 2'(mode); cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    cyc = 0;
    while (expQ.size() > 0) begin
      e = expQ.pop_front();
      tgt = e[2];
      check(sclOut === e[0] && sdaOut === e[1], (cyc == 0) ? "R2" : (e[5] ? "R6" : "R3"),
            $sformatf("%s scl/sda cycle %0d", tag, cyc), {sclOut, sdaOut}, {e[0], e[1]});
      check(busy === 1'b1 && done === 1'b0 && error === 1'b0, "R2",
            $sformatf("%s busy/done/error cycle %0d", tag, cyc), {busy, done, error}, 3'b100);
      check(wrTake === e[3], "R7", $sformatf("%s wrTake cycle %0d", tag, cyc), wrTake, e[3]);
      check(rdValid === e[4], "R8", $sformatf("%s rdValid cycle %0d", tag, cyc), rdValid, e[4]);
      if (e[4]) begin
        logic [7:0] xb;
        xb = rxQ.pop_front();
        check(rdData === xb, "R8", {tag, " rdData"}, rdData, xb);
      end
      if (e[3]) begin
        wi++;
        wrData = txBytes[(wi < 8) ? wi : 7];
      end
      if (poke && cyc == 20) begin cmdStart = 1'b1; cmdAddr = 10'h3AA; cmdRead = ~rd; end
      if (poke && cyc == 21) begin cmdStart = 1'b0; cmdAddr = a; cmdRead = rd; end
      cyc++;
      @(negedge clk);
    end
    tgt = 1'b1;
    check(done === 1'b1 && busy === 1'b0, "R11", {tag, " done pulse"}, {done, busy}, 2'b10);
    check(error === modelErr, modelErr ? "R9" : "R11", {tag, " error at done"}, error, modelErr);
    check(sclOut === 1'b1 && sdaOut === 1'b1, "R1", {tag, " lines after"}, {sclOut, sdaOut}, 2'b11);
    @(negedge clk);
    check(done === 1'b0 && error === modelErr, "R11", {tag, " done falls, error held"},
          {done, error}, {1'b0, modelErr});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    txBytes[0] = 8'h3C; txBytes[1] = 8'hC5; txBytes[2] = 8'h5A; txBytes[3] = 8'h81;
    for (int i = 4; i < 8; i++) txBytes[i] = 8'(i * 17);
    rxBytes[0] = 8'h96; rxBytes[1] = 8'h0F; rxBytes[2] = 8'hE1;
    for (int i = 3; i < 8; i++) rxBytes[i] = 8'(i * 29);
    nackMask = 0; holdIdx = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sclOut === 1 && sdaOut === 1 && busy === 0 && done === 0 && error === 0, "R1",
          "reset state", {sclOut, sdaOut, busy, done, error}, 5'b11000);
    // R4: 0x51 write gives header 0xA2; R12: mid-transfer start ignored
    runTxn("R4", 10'h051, 0, 0, 2, 0, 1);
    runTxn("R8", 10'h02C, 0, 1, 3, 1, 0);
    runTxn("R5", 10'h2B5, 1, 0, 1, 2, 0);
    nackMask = 1;
    runTxn("R9", 10'h010, 0, 0, 2, 0, 0);
    nackMask = 4;
    runTxn("R9", 10'h022, 0, 0, 3, 1, 0);
    nackMask = 0; holdIdx = 1;
    runTxn("R10", 10'h033, 0, 0, 2, 1, 0);
    holdIdx = -1;
    runTxn("R12", 10'h044, 0, 0, 0, 0, 0);
    runTxn("R5", 10'h3FF, 1, 1, 2, 1, 0);
    runTxn("R8", 10'h07F, 0, 1, 1, 3, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule